// File: doc/BRIEF.md
# Parallel Bus Region Timing Generator

This block runs the strobes of one chip-select region on an asynchronous external parallel bus, for example a compact-flash port used in PIO mode. A host starts an access through a simple request port that carries the direction, the address and the write data. The block then drives chip enable, output enable and write enable through a fixed series of phases. At the end it returns the read data and a one-clock completion pulse.

The length of each phase comes from a configuration field. A field value N gives N+1 units, and one unit is a selectable power-of-two number of clocks. The phases are address setup, enable-to-strobe, strobe width, hold and trailing pause. Reads and writes have their own strobe-width and hold fields. When dynamic waiting is enabled, the device's ready line can stretch the strobe. Read data is taken on the clock edge at which output enable is released.

Top module: `pbt_region_ctrl`

## Requirements
- R1: Out of reset, bus_ce_n, bus_oe_n and bus_we_n are high, bus_dout_oe and rsp_done are low, and req_ready is high while cfg_en is high.
- R2: An accepted access first holds bus_ce_n high for (cfg_adr+1)*M clocks. It then holds bus_ce_n low with both strobes high for (cfg_ce+1)*M clocks. M is the multiple selected by cfg_mult_sel.
- R3: The strobe is bus_oe_n on a read (req_write=0) and bus_we_n on a write (req_write=1). It stays low for (cfg_oe+1)*M or (cfg_we+1)*M clocks respectively. The two strobes are never low together, and a strobe is only low while bus_ce_n is low.
- R4: After the strobe rises, bus_ce_n stays low for (cfg_rd_hold+1)*M clocks on a read or (cfg_wr_hold+1)*M clocks on a write. It is then high for (cfg_pause+1)*M clocks. After that, rsp_done is high for exactly one clock.
- R5: cfg_mult_sel values 0, 1, 2 and 3 select a multiple M of 1, 2, 4 and 8 clocks.
- R6: With cfg_wait_en high, the strobe ends on the first clock edge at which both of these hold: its programmed width has elapsed, and bus_ready is high after SYNC_STAGES flops. If bus_ready rises D clocks after the strobe falls, the strobe width is max((field+1)*M, D+SYNC_STAGES+1).
- R7: With cfg_wait_en low, bus_ready is ignored and the strobe width is the programmed width.
- R8: On a read, rsp_rdata holds the bus_din value present at the clock edge where bus_oe_n rises. It keeps that value until the next read captures.
- R9: With cfg_en low, req_ready is low and req_valid is ignored: no strobe falls and no rsp_done occurs.
- R10: A request is accepted only while the block is idle. While an access is running, req_ready is low and a raised req_valid starts nothing, both during the access and after it ends.
- R11: bus_addr, and on writes bus_dout, keep the request's values through the whole access. bus_dout_oe is high only on writes, from the address phase through the hold phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Region enable |
| cfg_mult_sel | input | SEL_W | Timing multiple select (M = 2^value) |
| cfg_wait_en | input | 1 | Allow bus_ready to stretch the strobe |
| cfg_adr | input | FIELD_W | Address setup before chip enable, minus one |
| cfg_ce | input | FIELD_W | Chip enable to strobe, minus one |
| cfg_oe | input | FIELD_W | Read strobe width, minus one |
| cfg_we | input | FIELD_W | Write strobe width, minus one |
| cfg_rd_hold | input | FIELD_W | Chip enable hold after a read strobe, minus one |
| cfg_wr_hold | input | FIELD_W | Chip enable hold after a write strobe, minus one |
| cfg_pause | input | FIELD_W | Trailing pause, minus one |
| req_valid | input | 1 | Start an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Idle and enabled; a request is taken this clock |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Bus write data |
| bus_dout_oe | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Bus read data |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_ready | input | 1 | Device ready (asynchronous) |

## Verification
The bench builds the block with FIELD_W=4, SEL_W=2, ADDR_W=8, DATA_W=16 and SYNC_STAGES=2. The narrow fields keep even the longest phase short: field 15 at the 8x multiple is 128 clocks. That lets every multiple value run within a short run, including zero fields at 1x, the minimum one-clock phases. With two synchronizer stages, the ready-stretch case has a known latency of D+3 clocks, so the bench can place ready both before and after the programmed width has elapsed.

// File: rtl/pbt_pkg.sv
// Package: shared phase type and sequencing helper for the region timing generator.
// Assumes one access at a time per region.
package pbt_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADR  = 3'd1,
        PH_CE   = 3'd2,
        PH_ACT  = 3'd3,
        PH_HLD  = 3'd4,
        PH_PAU  = 3'd5
    } pbt_phase_e;

    // Successor of a phase in the fixed access order.
    function automatic pbt_phase_e pbt_succ(input pbt_phase_e p);
        case (p)
            PH_IDLE: return PH_ADR;
            PH_ADR:  return PH_CE;
            PH_CE:   return PH_ACT;
            PH_ACT:  return PH_HLD;
            PH_HLD:  return PH_PAU;
            default: return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/pbt_len.sv
// Module: pbt_len
// Turns a minus-one phase field into a length in clocks: (field+1) << sel.
// Assumes sel is stable while a phase is loaded. Pure combinational logic.
module pbt_len #(
    parameter int FIELD_W = 6,
    parameter int SEL_W   = 2
) (
    input  logic [FIELD_W-1:0]              field,
    input  logic [SEL_W-1:0]                sel,
    output logic [FIELD_W+(1<<SEL_W)-1:0]   len
);
    localparam int NSEL  = 1 << SEL_W;
    localparam int LEN_W = FIELD_W + NSEL;

    logic [LEN_W-1:0] base;
    logic [LEN_W-1:0] cand [NSEL];

    // Field plus one, widened so every shift fits.
    assign base = LEN_W'(field) + LEN_W'(1);

    // One shifted candidate per multiple; the select picks one of them.
    for (genvar s = 0; s < NSEL; s++) begin : g_shift
        assign cand[s] = base << s;
    end

    assign len = cand[sel];

endmodule

// File: rtl/pbt_sync.sv
// Module: pbt_sync
// Brings the asynchronous device ready line into the clock domain through
// STAGES flops. STAGES=0 passes it straight through, for a line that is
// already synchronous.
module pbt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    if (STAGES == 0) begin : g_pass
        logic unused_ok;
        assign unused_ok = clk ^ rst_n;
        assign q = d;
    end else begin : g_chain
        logic [STAGES-1:0] chain;
        // Shift the ready level through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2+((STAGES==1)?1:0):0], d};
        end
        assign q = chain[STAGES-1];
    end

endmodule

// File: rtl/pbt_seq.sv
// Module: pbt_seq
// Phase sequencer. It steps through address setup, enable-to-strobe, strobe,
// hold and pause, each lasting (field+1)*M clocks. On the strobe it waits for
// synchronized ready when dynamic waiting is on. It raises a one-clock done.
// Assumes the configuration is stable while an access is in flight.
module pbt_seq
    import pbt_pkg::*;
#(
    parameter int FIELD_W = 6,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic               cfg_wait_en,
    input  logic [FIELD_W-1:0] cfg_adr,
    input  logic [FIELD_W-1:0] cfg_ce,
    input  logic [FIELD_W-1:0] cfg_oe,
    input  logic [FIELD_W-1:0] cfg_we,
    input  logic [FIELD_W-1:0] cfg_rd_hld,
    input  logic [FIELD_W-1:0] cfg_wr_hld,
    input  logic [FIELD_W-1:0] cfg_pause,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               ready_s,
    output pbt_phase_e         phase_q,
    output pbt_phase_e         phase_d,
    output logic               write_d,
    output logic               accept,
    output logic               capture,
    output logic               done,
    output logic               req_ready
);
    localparam int LEN_W = FIELD_W + (1 << SEL_W);

    logic [LEN_W-1:0]   cnt_q, cnt_d, len;
    logic [FIELD_W-1:0] field;
    logic               write_q, wr_sel, done_d;
    pbt_phase_e         succ;

    pbt_len #(.FIELD_W(FIELD_W), .SEL_W(SEL_W)) u_len (
        .field (field),
        .sel   (cfg_sel),
        .len   (len)
    );

    // Pick the field of the phase to be loaded next.
    always_comb begin
        succ   = pbt_succ(phase_q);
        wr_sel = (phase_q == PH_IDLE) ? req_write : write_q;
        case (succ)
            PH_ADR:  field = cfg_adr;
            PH_CE:   field = cfg_ce;
            PH_ACT:  field = wr_sel ? cfg_we : cfg_oe;
            PH_HLD:  field = wr_sel ? cfg_wr_hld : cfg_rd_hld;
            PH_PAU:  field = cfg_pause;
            default: field = '0;
        endcase
    end

    // Next phase, counter, accept, capture and done decisions.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        capture = 1'b0;
        done_d  = 1'b0;
        if (phase_q == PH_IDLE) begin
            if (req_valid && cfg_en) begin
                accept  = 1'b1;
                phase_d = PH_ADR;
                cnt_d   = len - LEN_W'(1);
            end
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - LEN_W'(1);
        end else if (phase_q == PH_ACT && cfg_wait_en && !ready_s) begin
            cnt_d = '0;
        end else begin
            phase_d = succ;
            cnt_d   = (succ == PH_IDLE) ? '0 : len - LEN_W'(1);
            capture = (phase_q == PH_ACT) && !write_q;
            done_d  = (phase_q == PH_PAU);
        end
        write_d = accept ? req_write : write_q;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            write_q <= 1'b0;
            done    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            write_q <= write_d;
            done    <= done_d;
        end
    end

    assign req_ready = (phase_q == PH_IDLE) && cfg_en;

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_pause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(phase_q) == PH_PAU);
    assert_no_restart_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q inside {PH_CE, PH_ACT, PH_HLD, PH_PAU}) |=> phase_q != PH_ADR);
    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && !cfg_en) |=> phase_q == PH_IDLE);
    assert_wait_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ACT && cnt_q == '0 && cfg_wait_en && !ready_s) |=> phase_q == PH_ACT);
    assert_ready_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ACT && cnt_q == '0 && !cfg_wait_en) |=> phase_q == PH_HLD);

endmodule

// File: rtl/pbt_pins.sv
// Module: pbt_pins
// Bus-side registers. It registers the strobes from the next phase so each
// pin is a flop output with no decode glitch. It latches address and write
// data when an access is accepted, and captures read data on the edge that
// releases output enable.
module pbt_pins
    import pbt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pbt_phase_e        phase_q,
    input  pbt_phase_e        phase_d,
    input  logic              write_d,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_oe,
    output logic              bus_ce_n,
    output logic              bus_oe_n,
    output logic              bus_we_n,
    output logic [DATA_W-1:0] rsp_rdata
);
    // Strobe and drive-enable flops, loaded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ce_n    <= 1'b1;
            bus_oe_n    <= 1'b1;
            bus_we_n    <= 1'b1;
            bus_dout_oe <= 1'b0;
        end else begin
            bus_ce_n    <= !(phase_d inside {PH_CE, PH_ACT, PH_HLD});
            bus_oe_n    <= !(phase_d == PH_ACT && !write_d);
            bus_we_n    <= !(phase_d == PH_ACT && write_d);
            bus_dout_oe <= write_d && (phase_d inside {PH_ADR, PH_CE, PH_ACT, PH_HLD});
        end
    end

    // Address and write data, held from acceptance to the next acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr <= '0;
            bus_dout <= '0;
        end else if (accept) begin
            bus_addr <= req_addr;
            bus_dout <= req_wdata;
        end
    end

    // Read data capture at the output-enable release edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       rsp_rdata <= '0;
        else if (capture) rsp_rdata <= bus_din;
    end

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n));
    assert_strobe_in_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n || !bus_we_n) |-> !bus_ce_n);
    assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> ($stable(bus_addr) && $stable(bus_dout)));
    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture) |-> $stable(rsp_rdata));

endmodule

// File: rtl/pbt_region_ctrl.sv
// Module: pbt_region_ctrl (top)
// Timing generator for one chip-select region of an asynchronous parallel bus.
// It takes a request, runs the phased chip-enable / output-enable /
// write-enable sequence with lengths set by the configuration fields, and
// returns read data and a done pulse. Assumes the configuration is stable
// while an access runs, and that bus_din settles before the strobe releases.
module pbt_region_ctrl
    import pbt_pkg::*;
#(
    parameter int FIELD_W     = 6,
    parameter int SEL_W       = 2,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic [SEL_W-1:0]   cfg_mult_sel,
    input  logic               cfg_wait_en,
    input  logic [FIELD_W-1:0] cfg_adr,
    input  logic [FIELD_W-1:0] cfg_ce,
    input  logic [FIELD_W-1:0] cfg_oe,
    input  logic [FIELD_W-1:0] cfg_we,
    input  logic [FIELD_W-1:0] cfg_rd_hold,
    input  logic [FIELD_W-1:0] cfg_wr_hold,
    input  logic [FIELD_W-1:0] cfg_pause,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               rsp_done,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_dout,
    output logic               bus_dout_oe,
    input  logic [DATA_W-1:0]  bus_din,
    output logic               bus_ce_n,
    output logic               bus_oe_n,
    output logic               bus_we_n,
    input  logic               bus_ready
);
    pbt_phase_e phase_q, phase_d;
    logic       write_d, accept, capture, ready_s;

    pbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_ready),
        .q     (ready_s)
    );

    pbt_seq #(.FIELD_W(FIELD_W), .SEL_W(SEL_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_en      (cfg_en),
        .cfg_sel     (cfg_mult_sel),
        .cfg_wait_en (cfg_wait_en),
        .cfg_adr     (cfg_adr),
        .cfg_ce      (cfg_ce),
        .cfg_oe      (cfg_oe),
        .cfg_we      (cfg_we),
        .cfg_rd_hld  (cfg_rd_hold),
        .cfg_wr_hld  (cfg_wr_hold),
        .cfg_pause   (cfg_pause),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .ready_s     (ready_s),
        .phase_q     (phase_q),
        .phase_d     (phase_d),
        .write_d     (write_d),
        .accept      (accept),
        .capture     (capture),
        .done        (rsp_done),
        .req_ready   (req_ready)
    );

    pbt_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_q     (phase_q),
        .phase_d     (phase_d),
        .write_d     (write_d),
        .accept      (accept),
        .capture     (capture),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .bus_din     (bus_din),
        .bus_addr    (bus_addr),
        .bus_dout    (bus_dout),
        .bus_dout_oe (bus_dout_oe),
        .bus_ce_n    (bus_ce_n),
        .bus_oe_n    (bus_oe_n),
        .bus_we_n    (bus_we_n),
        .rsp_rdata   (rsp_rdata)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (bus_ce_n && bus_oe_n && bus_we_n && !rsp_done && !bus_dout_oe));

endmodule

// File: tb/pbt_region_ctrl_test.sv
// Scoreboard bench: the driver pushes expected phase lengths into a queue,
// and the monitor measures the pins and compares them when an access completes.
module pbt_region_ctrl_test;
    localparam int FW = 4, SW = 2, AW = 8, DW = 16, SYNC = 2;

    logic clk = 0, rst_n = 0;
    logic cfg_en = 1, cfg_wait_en = 0;
    logic [SW-1:0] cfg_mult_sel = '0;
    logic [FW-1:0] cfg_adr = 0, cfg_ce = 0, cfg_oe = 0, cfg_we = 0;
    logic [FW-1:0] cfg_rd_hold = 0, cfg_wr_hold = 0, cfg_pause = 0;
    logic req_valid = 0, req_write = 0, bus_ready = 0;
    logic [AW-1:0] req_addr = 0;
    logic [DW-1:0] req_wdata = 0, bus_din = 0;
    logic req_ready, rsp_done, bus_dout_oe, bus_ce_n, bus_oe_n, bus_we_n;
    logic [DW-1:0] rsp_rdata, bus_dout;
    logic [AW-1:0] bus_addr;

    always #4 clk = ~clk;

    pbt_region_ctrl #(.FIELD_W(FW), .SEL_W(SW), .ADDR_W(AW), .DATA_W(DW),
                      .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mult_sel(cfg_mult_sel),
        .cfg_wait_en(cfg_wait_en), .cfg_adr(cfg_adr), .cfg_ce(cfg_ce),
        .cfg_oe(cfg_oe), .cfg_we(cfg_we), .cfg_rd_hold(cfg_rd_hold),
        .cfg_wr_hold(cfg_wr_hold), .cfg_pause(cfg_pause), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe),
        .bus_din(bus_din), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n), .bus_ready(bus_ready));

    typedef struct {
        int adr, ce, act, hld, pau;
        bit wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0, done_cnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int plen(input int f, input int sel);
        return (f + 1) << sel;
    endfunction

    // Monitor: measure each phase at posedge+2 and compare with the queue.
    initial begin
        exp_t e;
        int stage = 0, cnt = 0, k = 0;
        bit in_cyc = 0, prev_rdy = 0, chk_pulse = 0;
        logic [DW-1:0] last_din = 0;
        forever begin
            @(posedge clk); #2;
            if (rst_n) begin
                chk(!(!bus_oe_n && !bus_we_n), "R3 strobe exclusive", 0, 0);
                if (chk_pulse) begin
                    chk(!rsp_done, "R4 done one clock", int'(rsp_done), 0);
                    chk_pulse = 0;
                end
                if (!in_cyc) begin
                    if (prev_rdy && !req_ready && cfg_en) begin
                        if (exp_q.size() == 0) chk(0, "R10 unexpected start", 1, 0);
                        else begin
                            e = exp_q.pop_front();
                            in_cyc = 1; stage = 0; cnt = 1; k = 0;
                        end
                    end
                end else begin
                    chk(bus_addr == e.addr, "R11 address held", int'(bus_addr), int'(e.addr));
                    case (stage)
                        0: if (bus_ce_n) cnt++;
                           else begin
                               chk(cnt == e.adr, "R2 address phase", cnt, e.adr);
                               stage = 1; cnt = 1;
                           end
                        1: if (bus_oe_n && bus_we_n) cnt++;
                           else begin
                               chk(cnt == e.ce, "R2 enable-to-strobe", cnt, e.ce);
                               if (e.wr) begin
                                   chk(!bus_we_n && bus_oe_n, "R3 write strobe", int'(bus_we_n), 0);
                                   chk(bus_dout_oe && bus_dout == e.wdata, "R11 write data", int'(bus_dout), int'(e.wdata));
                               end else begin
                                   chk(!bus_oe_n && bus_we_n && !bus_dout_oe, "R3 read strobe", int'(bus_oe_n), 0);
                                   k++; bus_din = e.wdata ^ DW'(k); last_din = bus_din;
                               end
                               stage = 2; cnt = 1;
                           end
                        2: if (!(bus_oe_n && bus_we_n)) begin
                               cnt++;
                               if (!e.wr) begin k++; bus_din = e.wdata ^ DW'(k); last_din = bus_din; end
                           end else begin
                               chk(cnt == e.act, "R3/R6/R7 strobe width", cnt, e.act);
                               chk(!bus_ce_n, "R4 hold ce low", int'(bus_ce_n), 0);
                               stage = 3; cnt = 1;
                           end
                        3: if (!bus_ce_n) cnt++;
                           else begin
                               chk(cnt == e.hld, "R4 hold phase", cnt, e.hld);
                               stage = 4; cnt = 1;
                           end
                        default: if (!rsp_done) cnt++;
                           else begin
                               chk(cnt == e.pau, "R4 pause phase", cnt, e.pau);
                               if (!e.wr) chk(rsp_rdata == last_din, "R8 read capture", int'(rsp_rdata), int'(last_din));
                               in_cyc = 0; chk_pulse = 1; done_cnt++;
                           end
                    endcase
                end
                prev_rdy = req_ready;
            end
        end
    end

    // Driver: program the region, issue one access, push the expectation.
    task automatic run_cycle(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input int sel, input int adr, input int ce, input int oe,
                             input int we, input int rh, input int wh, input int pa,
                             input bit wen, input bit rdy0, input int dly);
        exp_t e;
        int target;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_mult_sel = SW'(sel); cfg_adr = FW'(adr); cfg_ce = FW'(ce); cfg_oe = FW'(oe);
        cfg_we = FW'(we); cfg_rd_hold = FW'(rh); cfg_wr_hold = FW'(wh); cfg_pause = FW'(pa);
        cfg_wait_en = wen; bus_ready = rdy0;
        req_write = wr; req_addr = a; req_wdata = d;
        e.adr = plen(adr, sel); e.ce = plen(ce, sel);
        e.act = wr ? plen(we, sel) : plen(oe, sel);
        e.hld = wr ? plen(wh, sel) : plen(rh, sel);
        e.pau = plen(pa, sel); e.wr = wr; e.addr = a; e.wdata = d;
        if (wen && !rdy0 && (dly + SYNC + 1) > e.act) e.act = dly + SYNC + 1;
        exp_q.push_back(e);
        target = done_cnt + 1;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        if (wen && !rdy0) begin
            do begin @(posedge clk); #2; end while (bus_oe_n && bus_we_n);
            repeat (dly) begin @(posedge clk); #2; end
            bus_ready = 1;
        end
        wait (done_cnt == target);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #2;
        chk(bus_ce_n && bus_oe_n && bus_we_n, "R1 strobes idle", int'(bus_ce_n), 1);
        chk(!rsp_done && !bus_dout_oe, "R1 done/oe low", int'(rsp_done), 0);
        chk(req_ready, "R1 ready when enabled", int'(req_ready), 1);

        // R2 R3 R4 R5 R8: reads and writes at each multiple, distinct fields.
        run_cycle(0, 8'h11, 16'hA500, 1, 1, 0, 3, 7, 1, 4, 2, 0, 0, 0);
        run_cycle(1, 8'h22, 16'h1234, 1, 0, 2, 9, 2, 5, 0, 1, 0, 0, 0);
        run_cycle(0, 8'h33, 16'h0F0F, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        run_cycle(1, 8'h44, 16'hBEEF, 3, 2, 1, 0, 3, 0, 1, 2, 0, 0, 0);
        run_cycle(0, 8'h55, 16'h7700, 2, 0, 1, 4, 1, 2, 0, 0, 0, 0, 0);
        run_cycle(0, 8'h56, 16'h3C00, 3, 0, 0, 15, 0, 0, 0, 0, 0, 0, 0);
        // R6: ready late stretches, early or preset ready leaves the width.
        run_cycle(0, 8'h66, 16'h9900, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 5);
        run_cycle(1, 8'h67, 16'hCAFE, 1, 0, 0, 0, 5, 0, 0, 0, 1, 0, 2);
        run_cycle(0, 8'h68, 16'h4400, 0, 1, 0, 2, 0, 0, 0, 0, 1, 1, 0);
        run_cycle(0, 8'h69, 16'h5500, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 12);
        // R7: wait disabled, ready held low.
        run_cycle(1, 8'h77, 16'h0102, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);

        // R9: region disabled ignores a held request.
        @(negedge clk); cfg_en = 0; req_valid = 1; req_addr = 8'h99;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #2;
            chk(bus_ce_n && !rsp_done && !req_ready, "R9 disabled ignores request", int'(bus_ce_n), 1);
        end
        @(negedge clk); req_valid = 0; cfg_en = 1;
        @(posedge clk); #2;
        chk(bus_ce_n && req_ready, "R9 idle after enable", int'(req_ready), 1);

        // R10: request raised while busy starts nothing.
        fork
            run_cycle(0, 8'hA0, 16'h2200, 3, 3, 0, 1, 1, 0, 0, 0, 0, 0, 0);
            begin
                repeat (5) @(negedge clk);
                req_valid = 1; req_addr = 8'hEE;
                repeat (20) @(negedge clk);
                req_valid = 0;
            end
        join
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #2;
            chk(req_ready && bus_ce_n, "R10 no access after busy request", int'(req_ready), 1);
        end
        chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule